// File: doc/BRIEF.md
# Flash Status Auto-Poll Unit

This block takes over the wait for a serial NOR flash to become ready after a program or erase. It reads the flash status byte again and again, each time as its own four-line transaction. The block sends a one-byte read-status command, reads one status byte back over the same four lines, and checks it against a masked match value. It leaves chip select high for a set number of clocks between reads. When the masked status equals the masked match value, polling stops, `done` pulses for one clock and `busy` drops. The host never has to fetch status bytes itself.

The host sets the mask, the match value and the gap length, then pulses `start`. These three settings are captured when `start` is accepted. The usual setup is mask 0x01, match 0x00 and a gap of 16 clocks, which waits for the write-in-progress bit to clear. The pin side drives the block's share of a QSPI shifter. It has an active-low select, a clock-enable that marks the bus clocks, a four-bit output with an output enable, and a four-bit input that is sampled at the rising edge. One bus clock equals one clock of `clk`.

Top module: `flash_status_poller`

## Requirements
- R1: Each poll holds `csN` low for exactly 4 clocks. In the first two of them `ioOe` is 1 and `ioOut` carries the command 0x05 high nibble first: 0x0, then 0x5.
- R2: In the last two low clocks of a poll `ioOe` is 0. The status byte is assembled from `ioIn`: the nibble sampled in the third clock forms bits 7:4 and the nibble in the fourth clock forms bits 3:0.
- R3: A poll matches when `(status & mask) == (match & mask)`. With a mask of 0 the first poll always matches.
- R4: On a match, in the clock right after the fourth low clock, `done` is 1, `busy` is 0 and `csN` stays high. `done` is 1 for exactly one clock.
- R5: After a poll that does not match, `csN` stays high for exactly G clocks before the next poll begins. G is the captured gap value, and a gap value of 0 counts as 1.
- R6: `busy` rises in the clock after `start` is accepted and stays high until the match. While `busy` is high, `start` and changes on `statusMask`, `matchValue` and `gapClocks` have no effect on the transactions.
- R7: After reset, `csN`=1, `sckEn`=0, `ioOe`=0, `busy`=0, `done`=0 and `lastStatus`=0.
- R8: `sckEn` is 1 exactly in the clocks where `csN` is 0.
- R9: `lastStatus` shows the status byte of every finished poll, including polls that do not match, from the clock after its fourth low clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus clock per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling; accepted only when not busy |
| statusMask | input | 8 | Bits of the status byte that take part in the compare |
| matchValue | input | 8 | Wanted value of the masked bits |
| gapClocks | input | 8 | Clocks with select high between polls (0 means 1) |
| done | output | 1 | One-clock pulse on a match |
| busy | output | 1 | Polling in progress |
| lastStatus | output | 8 | Most recent status byte read |
| csN | output | 1 | Flash chip select, active low |
| sckEn | output | 1 | Bus clock enable for the shifter |
| ioOut | output | 4 | Data nibble driven to the flash |
| ioOe | output | 1 | Output enable for ioOut |
| ioIn | input | 4 | Data nibble returned by the flash |

## Verification
The bench models the flash as a list of status bytes, one per poll. The byte that matches sits at a chosen position. A directed run uses the usual write-in-progress setup, with a busy byte that also has other bits set. This shows that only masked bits count. Random runs vary the mask, the match value, the gap (zero and one included) and the number of polls that fail. This separates a wrong compare or a wrong nibble order from a wrong gap count. During some runs `start` is pulsed and the settings are changed while busy; a design that does not capture the settings would then end or pace the polls at the wrong point.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam logic [7:0] READ_STATUS_CMD = 8'h05;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_GAP
  } pollState_e;

  typedef struct packed {
    logic capture;   // latch host settings
    logic cmdDrive;  // drive command nibble
    logic nibSel;    // 0: high nibble, 1: low nibble
    logic sampleHi;  // take upper status nibble
    logic sampleLo;  // take lower status nibble, publish byte
  } pollStrobes_t;
endpackage

// File: rtl/poll_datapath.sv
module poll_datapath
  import poll_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int GAP_W = 8,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobes_t      strobes,
  input  logic [BYTE_W-1:0] statusMask,
  input  logic [BYTE_W-1:0] matchValue,
  input  logic [GAP_W-1:0]  gapClocks,
  input  logic [NIB_W-1:0]  ioIn,
  output logic [NIB_W-1:0]  ioOut,
  output logic              ioOe,
  output logic              matchNow,
  output logic [GAP_W-1:0]  gapEff,
  output logic [BYTE_W-1:0] lastStatus
);
  localparam logic [BYTE_W-1:0] CMD_CODE = BYTE_W'(READ_STATUS_CMD);

  logic [BYTE_W-1:0] maskReg, matchReg;
  logic [GAP_W-1:0]  gapReg;
  logic [NIB_W-1:0]  hiNib;
  logic [BYTE_W-1:0] liveByte;

  assign liveByte = {hiNib, ioIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg    <= '0;
      matchReg   <= '0;
      gapReg     <= '0;
      hiNib      <= '0;
      lastStatus <= '0;
    end else begin
      if (strobes.capture) begin
        maskReg  <= statusMask;
        matchReg <= matchValue;
        gapReg   <= gapClocks;
      end
      if (strobes.sampleHi) hiNib <= ioIn;
      if (strobes.sampleLo) lastStatus <= liveByte;
    end
  end

  assign matchNow = ((liveByte ^ matchReg) & maskReg) == '0;
  assign gapEff   = (gapReg == '0) ? GAP_W'(1) : gapReg;

  always_comb begin
    ioOe  = strobes.cmdDrive;
    ioOut = '0;
    if (strobes.cmdDrive)
      ioOut = strobes.nibSel ? CMD_CODE[NIB_W-1:0] : CMD_CODE[BYTE_W-1:NIB_W];
  end
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             matchNow,
  input  logic [GAP_W-1:0] gapEff,
  output pollStrobes_t     strobes,
  output logic             done,
  output logic             busy,
  output logic             csN,
  output logic             sckEn
);
  pollState_e       state;
  logic             nib;
  logic [GAP_W-1:0] gapCnt;
  logic             onBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nib    <= 1'b0;
      gapCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          nib <= 1'b0;
          if (start) state <= ST_CMD;
        end
        ST_CMD: begin
          nib <= ~nib;
          if (nib) state <= ST_DATA;
        end
        ST_DATA: begin
          nib <= ~nib;
          if (nib) begin
            if (matchNow) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state  <= ST_GAP;
              gapCnt <= gapEff - GAP_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (gapCnt == '0) state <= ST_CMD;
          else gapCnt <= gapCnt - GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign onBus = (state == ST_CMD) || (state == ST_DATA);
  assign csN   = ~onBus;
  assign sckEn = onBus;
  assign busy  = (state != ST_IDLE);

  always_comb begin
    strobes          = '0;
    strobes.capture  = (state == ST_IDLE) && start;
    strobes.cmdDrive = (state == ST_CMD);
    strobes.nibSel   = nib;
    strobes.sampleHi = (state == ST_DATA) && !nib;
    strobes.sampleLo = (state == ST_DATA) && nib;
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import poll_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int GAP_W = 8,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] statusMask,
  input  logic [BYTE_W-1:0] matchValue,
  input  logic [GAP_W-1:0]  gapClocks,
  output logic              done,
  output logic              busy,
  output logic [BYTE_W-1:0] lastStatus,
  output logic              csN,
  output logic              sckEn,
  output logic [NIB_W-1:0]  ioOut,
  output logic              ioOe,
  input  logic [NIB_W-1:0]  ioIn
);
  pollStrobes_t     strobes;
  logic             matchNow;
  logic [GAP_W-1:0] gapEff;

  poll_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .matchNow (matchNow),
    .gapEff   (gapEff),
    .strobes  (strobes),
    .done     (done),
    .busy     (busy),
    .csN      (csN),
    .sckEn    (sckEn)
  );

  poll_datapath #(.NIB_W(NIB_W), .GAP_W(GAP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .statusMask (statusMask),
    .matchValue (matchValue),
    .gapClocks  (gapClocks),
    .ioIn       (ioIn),
    .ioOut      (ioOut),
    .ioOe       (ioOe),
    .matchNow   (matchNow),
    .gapEff     (gapEff),
    .lastStatus (lastStatus)
  );
endmodule

// File: rtl/poll_checker.sv
module poll_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic done,
  input logic busy,
  input logic csN,
  input logic ioOe
);
  // R4: completion is reported with busy already low
  assert_doneIdle_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && csN));

  // R4: done is a single-clock pulse
  assert_donePulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: the command is only driven inside a selected transaction
  assert_driveInFrame_R1: assert property (@(posedge clk) disable iff (!rstN)
    ioOe |-> !csN);

  // R2: select rises only after the read phase, never straight after driving
  assert_readBeforeRelease_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !$past(ioOe));

  // R6: polling only begins after a start request
  assert_busyFromStart_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R4: done always follows a bus clock
  assert_doneAfterRead_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!csN));
endmodule

bind flash_status_poller poll_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .done  (done),
  .busy  (busy),
  .csN   (csN),
  .ioOe  (ioOe)
);

// File: tb/sim_flash_status_poller.sv
`timescale 1ns/1ps
module sim_flash_status_poller;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] statusMask = '0;
  logic [7:0] matchValue = '0;
  logic [7:0] gapClocks = '0;
  logic       done, busy, csN, sckEn, ioOe;
  logic [7:0] lastStatus;
  logic [3:0] ioOut;
  logic [3:0] ioIn = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timedOut = 0;
  logic [7:0] polls [8];

  always #2.5 clk = ~clk;

  flash_status_poller u0 (
    .clk(clk), .rstN(rstN), .start(start), .statusMask(statusMask),
    .matchValue(matchValue), .gapClocks(gapClocks), .done(done), .busy(busy),
    .lastStatus(lastStatus), .csN(csN), .sckEn(sckEn), .ioOut(ioOut),
    .ioOe(ioOe), .ioIn(ioIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > 150000) timedOut = 1;
  endtask

  function automatic bit isMatch(input logic [7:0] b, input logic [7:0] m, input logic [7:0] v);
    return ((b ^ v) & m) == 8'h00;
  endfunction

  function automatic int effGap(input logic [7:0] g);
    return (g == 0) ? 1 : int'(g);
  endfunction

  // Fill polls[0..k-1]: only the last one matches
  task automatic buildPolls(input logic [7:0] m, input logic [7:0] v, inout int k);
    if (m == 0) k = 1;
    for (int i = 0; i < k - 1; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (isMatch(b, m, v)) b = b ^ (m & (~m + 8'd1));
      polls[i] = b;
    end
    polls[k-1] = (8'($urandom) & ~m) | (v & m);
  endtask

  task automatic runPoll(input logic [7:0] m, input logic [7:0] v, input logic [7:0] g,
                         input int k, input bit disturb);
    int txIdx = 0;
    int poll = 0;
    int gapRun = 0;
    bit fin = 0;
    statusMask = m; matchValue = v; gapClocks = g; start = 1'b1;
    tick();
    start = 1'b0;
    check(busy === 1'b1, "R6 busy after start", busy, 1);
    while (!fin && !timedOut) begin
      start = 1'b0;
      check(sckEn === !csN, "R8 sckEn vs csN", sckEn, !csN);
      if (!csN) begin
        if (gapRun > 0) check(gapRun == effGap(g), "R5 gap length", gapRun, effGap(g));
        gapRun = 0;
        check(busy === 1'b1, "R6 busy during poll", busy, 1);
        if (txIdx < 2) begin
          check(ioOe === 1'b1 && ioOut === (txIdx == 0 ? 4'h0 : 4'h5),
                "R1 command nibble", ioOut, txIdx == 0 ? 0 : 5);
          if (disturb && txIdx == 1 && ($urandom % 2) == 1) begin
            start = 1'b1;
            statusMask = 8'($urandom);
            matchValue = 8'($urandom);
            gapClocks = 8'($urandom % 24);
          end
        end else begin
          check(ioOe === 1'b0, "R2 bus released in read", ioOe, 0);
          ioIn = (txIdx == 2) ? polls[poll][7:4] : polls[poll][3:0];
        end
        txIdx++;
      end else begin
        if (txIdx > 0) begin
          check(txIdx == 4, "R1 poll length", txIdx, 4);
          if (poll == k - 1) begin
            check(done === 1'b1 && busy === 1'b0, "R4 done and busy on match",
                  {done, busy}, 2);
            check(lastStatus === polls[poll], "R3 matching status", lastStatus, polls[poll]);
            fin = 1;
          end else begin
            check(done === 1'b0 && busy === 1'b1, "R3 no stop on mismatch", {done, busy}, 1);
            check(lastStatus === polls[poll], "R9 status of failed poll", lastStatus, polls[poll]);
          end
          poll++;
          txIdx = 0;
          gapRun = 1;
        end else begin
          gapRun++;
        end
      end
      tick();
    end
    start = 1'b0;
    ioIn = '0;
    check(done === 1'b0 && busy === 1'b0 && csN === 1'b1, "R4 single done pulse",
          {done, busy, csN}, 1);
    check(poll == k, "R3 poll count", poll, k);
    tick();
  endtask

  initial begin
    void'($urandom(32'd7211));
    repeat (3) tick();
    check(csN === 1'b1 && sckEn === 1'b0 && ioOe === 1'b0, "R7 pins in reset",
          {csN, sckEn, ioOe}, 4);
    check(busy === 1'b0 && done === 1'b0 && lastStatus === 8'h00, "R7 status in reset",
          {busy, done, lastStatus}, 0);
    rstN = 1'b1;
    tick();

    // Directed: write-in-progress wait, 16-clock gap
    polls[0] = 8'h03; polls[1] = 8'hF1; polls[2] = 8'hFE;
    runPoll(8'h01, 8'h00, 8'd16, 3, 0);
    // Directed: mask 0 stops at once (R3)
    polls[0] = 8'h5A;
    runPoll(8'h00, 8'hFF, 8'd4, 1, 0);
    // Directed: gap 0 acts as 1 (R5), full-byte match
    polls[0] = 8'h12; polls[1] = 8'h34; polls[2] = 8'hA5;
    runPoll(8'hFF, 8'hA5, 8'd0, 3, 0);
    // Directed: gap 1 with settings disturbed while busy (R6)
    polls[0] = 8'h80; polls[1] = 8'h81; polls[2] = 8'h00;
    runPoll(8'h80, 8'h00, 8'd1, 3, 1);

    for (int t = 0; t < 40 && !timedOut; t++) begin
      logic [7:0] m, v, g;
      int k;
      m = (t % 4 == 0) ? 8'h01 : 8'($urandom);
      v = 8'($urandom);
      g = 8'($urandom % 21);
      k = 1 + int'($urandom % 6);
      buildPolls(m, v, k);
      runPoll(m, v, g, k, t % 2 == 1);
    end

    if (timedOut) check(0, "watchdog", cycles, 150000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule